// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps a short last-in-first-out record of how transmitted packets ended, and presents the newest record to the host as one status byte. When the transmit engine finishes a packet, it reports the outcome: a request-interrupt marker, jabber, underrun and maximum-collision flags. A record is kept when the packet failed or when the host asked to hear about it. The host sees the newest record all the time and removes it with a write strobe. Reading the byte does not consume the record.

The block also owns the transmitter's on/off state. A jabber or underrun outcome, or a transmit data overrun, switches the transmitter off and locks it off. While the lock is set, an enable command is ignored. Only a transmit-reset or global-reset command clears the lock. A transmit data overrun also produces a one-cycle adapter-failure event. Each record that enters the stack produces a one-cycle transmit-complete event.

Top module: `tx_done_stack`

## Requirements
- R1: The status byte holds these fields: bit 7 is set whenever a record is present, bit 6 is the request-interrupt marker, bit 5 is jabber, bit 4 is underrun, bit 3 is maximum collisions, bit 2 is stack overflow, and bits 1:0 are zero. The byte reflects a push or pop on the clock edge that performs it.
- R2: A completion with no error flag and no request marker is not recorded. A completion with the request marker set, or with any of jabber, underrun or maximum collisions set, pushes one record.
- R3: The byte always shows the most recently pushed record that is still held. Each cycle with `stat_pop` high removes that record.
- R4: With the stack empty, the byte reads 0x00 and a pop changes nothing.
- R5: A push onto a full stack (DEPTH records, no pop in the same cycle) is dropped and sets bit 2 in the top record. A pop then exposes the record beneath it with its own overflow bit.
- R6: `tx_done_evt` is high for exactly the cycle after each push that the stack accepts. It stays low for skipped and dropped pushes.
- R7: A recorded jabber or underrun outcome drives `tx_enabled` low on that edge and locks it. While locked, opcode 9 has no effect.
- R8: A `data_overrun` pulse drives `tx_enabled` low and locks it, and raises `adapter_fail_evt` for the following cycle.
- R9: Commands use 5-bit opcodes. Opcode 9 enables the transmitter when it is not locked. Opcode 10 disables it. Opcodes 11 (transmit reset) and 0 (global reset) empty the stack, clear the lock and leave the transmitter off. Any other opcode has no effect.
- R10: When a pop and a push fall in the same cycle, the pop happens first. A reset opcode takes precedence in its cycle over any push, pop or fatal outcome.
- R11: After `rst_n` is low at a clock edge, the stack is empty, the transmitter is off and unlocked, and both events are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| done_valid | input | 1 | A packet has finished this cycle |
| done_req_irq | input | 1 | Request-interrupt marker of the finished packet |
| done_jabber | input | 1 | Jabber outcome |
| done_underrun | input | 1 | Underrun outcome |
| done_max_coll | input | 1 | Maximum-collision outcome |
| data_overrun | input | 1 | Transmit data overrun pulse |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 5 | Command opcode |
| stat_pop | input | 1 | Host write to the status byte; pops the top record |
| stat_byte | output | 8 | Top record, formatted as in R1 |
| tx_enabled | output | 1 | Transmitter on |
| tx_done_evt | output | 1 | One-cycle pulse per accepted record |
| adapter_fail_evt | output | 1 | One-cycle pulse after a data overrun |

## Verification
The bench builds the block with DEPTH set to 3. This odd depth makes the counter width differ from a power-of-two case. It also lets a fourth push reach the overflow path within a few cycles, so the overflow bit can be watched through several pops. A queue-based model, compared on every clock, follows directed sequences and then a long random run. The directed sequences cover the lock against enable, pop-and-push in one cycle, and a reset opcode colliding with a jabber outcome. In the random run, pops, pushes and commands are dense enough to fill and drain the stack many times.

// File: rtl/tx_done_pkg.sv
// Package: shared record type, opcodes and formatting for the completion stack.
// Assumes a 5-bit command opcode field.
package tx_done_pkg;

    typedef struct packed {
        logic req;
        logic jab;
        logic und;
        logic maxc;
        logic ovf;
    } txd_ent_t;

    localparam int OPW = 5;
    localparam logic [OPW-1:0] OP_GLOBAL_RESET = 5'd0;
    localparam logic [OPW-1:0] OP_TX_ON        = 5'd9;
    localparam logic [OPW-1:0] OP_TX_OFF       = 5'd10;
    localparam logic [OPW-1:0] OP_TX_RESET     = 5'd11;

    // Format a record as the host-visible status byte; valid marks presence.
    function automatic logic [7:0] fmt_byte(input logic valid, input txd_ent_t e);
        return valid ? {1'b1, e.req, e.jab, e.und, e.maxc, e.ovf, 2'b00} : 8'h00;
    endfunction

endpackage

// File: rtl/txd_lifo.sv
// Module: txd_lifo
// A DEPTH-deep last-in-first-out store of completion records.
// In one cycle, a pop is applied before a push, and clr overrides both.
// A push onto a full store is dropped and marks overflow in the top slot.
// Assumes DEPTH >= 1.
module txd_lifo
    import tx_done_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  logic     push,
    input  txd_ent_t push_ent,
    input  logic     pop,
    output txd_ent_t top_ent,
    output logic     not_empty,
    output logic     accepted
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_mid;
    logic          pop_eff;
    logic          room;
    logic          drop;
    txd_ent_t      slots [DEPTH];

    // Pop-first occupancy and acceptance of the incoming push.
    always_comb begin
        pop_eff  = pop && (cnt != '0);
        cnt_mid  = cnt - CW'(pop_eff);
        room     = cnt_mid < FULL;
        accepted = push && room && !clr;
        drop     = push && !room && !clr;
    end

    // Occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_mid + CW'(accepted);
        end
    end

    // One register per slot: written on an accepted push, or overflow-marked at the top.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slots[i] <= '0;
            end else if (accepted && (cnt_mid == CW'(i))) begin
                slots[i]     <= push_ent;
                slots[i].ovf <= 1'b0;
            end else if (drop && (i == DEPTH - 1)) begin
                slots[i].ovf <= 1'b1;
            end
        end
    end

    // Select the top record.
    always_comb begin
        top_ent = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt == CW'(i + 1)) top_ent = slots[i];
        end
        not_empty = (cnt != '0);
    end

    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && pop && !push && !clr) |=> (cnt == '0)); // R4
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == FULL && push && !pop && !clr) |=> (cnt == FULL && top_ent.ovf)); // R5
    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clr && cnt < FULL) |=> (cnt == $past(cnt) + 1'b1)); // R2
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !not_empty); // R9

endmodule

// File: rtl/txd_gate.sv
// Module: txd_gate
// Transmitter on/off state with a lock that fatal outcomes set.
// Priority: reset opcode, then fatal, then enable, then disable.
// Assumes at most one command per cycle.
module txd_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_cmd,
    input  logic on_cmd,
    input  logic off_cmd,
    input  logic fatal,
    output logic enabled,
    output logic locked
);

    // Enable and lock state update.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_cmd) begin
            enabled <= 1'b0;
            locked  <= 1'b0;
        end else if (fatal) begin
            enabled <= 1'b0;
            locked  <= 1'b1;
        end else if (on_cmd && !locked) begin
            enabled <= 1'b1;
        end else if (off_cmd) begin
            enabled <= 1'b0;
        end
    end

    AST_LOCK_BLOCKS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !enabled && !rst_cmd) |=> !enabled); // R7
    AST_FATAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (fatal && !rst_cmd) |=> (!enabled && locked)); // R7
    AST_RST_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cmd |=> (!enabled && !locked)); // R9

endmodule

// File: rtl/tx_done_stack.sv
// Module: tx_done_stack (top)
// Transmit completion status stack with transmitter enable control.
// Decodes commands and completion outcomes, feeds the record store and the
// on/off gate, and registers the two one-cycle event outputs.
// Assumes inputs are synchronous to clk.
module tx_done_stack
    import tx_done_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           done_valid,
    input  logic           done_req_irq,
    input  logic           done_jabber,
    input  logic           done_underrun,
    input  logic           done_max_coll,
    input  logic           data_overrun,
    input  logic           cmd_valid,
    input  logic [OPW-1:0] cmd_op,
    input  logic           stat_pop,
    output logic [7:0]     stat_byte,
    output logic           tx_enabled,
    output logic           tx_done_evt,
    output logic           adapter_fail_evt
);

    logic     rst_cmd, on_cmd, off_cmd;
    logic     any_err, do_push, fatal;
    logic     accepted, not_empty, locked;
    txd_ent_t new_ent, top_ent;

    // Command and outcome decode.
    always_comb begin
        rst_cmd = cmd_valid && (cmd_op == OP_TX_RESET || cmd_op == OP_GLOBAL_RESET);
        on_cmd  = cmd_valid && (cmd_op == OP_TX_ON);
        off_cmd = cmd_valid && (cmd_op == OP_TX_OFF);
        any_err = done_jabber || done_underrun || done_max_coll;
        do_push = done_valid && (any_err || done_req_irq);
        fatal   = (done_valid && (done_jabber || done_underrun)) || data_overrun;
        new_ent = '{req: done_req_irq, jab: done_jabber, und: done_underrun,
                    maxc: done_max_coll, ovf: 1'b0};
    end

    txd_lifo #(.DEPTH(DEPTH)) u_lifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (rst_cmd),
        .push      (do_push),
        .push_ent  (new_ent),
        .pop       (stat_pop),
        .top_ent   (top_ent),
        .not_empty (not_empty),
        .accepted  (accepted)
    );

    txd_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_cmd (rst_cmd),
        .on_cmd  (on_cmd),
        .off_cmd (off_cmd),
        .fatal   (fatal),
        .enabled (tx_enabled),
        .locked  (locked)
    );

    // Event pulses, one cycle after their cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_done_evt      <= 1'b0;
            adapter_fail_evt <= 1'b0;
        end else begin
            tx_done_evt      <= accepted;
            adapter_fail_evt <= data_overrun;
        end
    end

    // Host-visible status byte.
    assign stat_byte = fmt_byte(not_empty, top_ent);

    AST_EVT_HAS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_evt |-> stat_byte[7]); // R6
    AST_FAIL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        data_overrun |=> adapter_fail_evt); // R8
    AST_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_byte[1:0] == 2'b00); // R1
    AST_SKIP_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_req_irq && !any_err && !rst_cmd && stat_pop) |=> !tx_done_evt); // R2

endmodule

// File: tb/tx_done_stack_bench.sv
module tx_done_stack_bench;

    localparam int DEPTH = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       done_valid = 0, done_req_irq = 0, done_jabber = 0, done_underrun = 0, done_max_coll = 0;
    logic       data_overrun = 0, cmd_valid = 0, stat_pop = 0;
    logic [4:0] cmd_op = '0;
    logic [7:0] stat_byte;
    logic       tx_enabled, tx_done_evt, adapter_fail_evt;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit model_on = 0;

    // Reference model state.
    logic [7:0] q[$];
    bit m_en = 0, m_lock = 0, m_evt = 0, m_fail = 0;

    always #10 clk = ~clk;

    tx_done_stack #(.DEPTH(DEPTH)) u_tx_done_stack (
        .clk(clk), .rst_n(rst_n),
        .done_valid(done_valid), .done_req_irq(done_req_irq), .done_jabber(done_jabber),
        .done_underrun(done_underrun), .done_max_coll(done_max_coll),
        .data_overrun(data_overrun), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .stat_pop(stat_pop), .stat_byte(stat_byte), .tx_enabled(tx_enabled),
        .tx_done_evt(tx_done_evt), .adapter_fail_evt(adapter_fail_evt)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic logic [7:0] model_top();
        return (q.size() == 0) ? 8'h00 : q[q.size()-1];
    endfunction

    // Behavioural model, advanced on every clock edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            q.delete(); m_en = 0; m_lock = 0; m_evt = 0; m_fail = 0;
        end else begin
            bit rc, fat, pu;
            rc  = cmd_valid && (cmd_op == 5'd0 || cmd_op == 5'd11);
            fat = (done_valid && (done_jabber || done_underrun)) || data_overrun;
            pu  = done_valid && (done_req_irq || done_jabber || done_underrun || done_max_coll);
            m_fail = data_overrun;
            m_evt = 0;
            if (rc) begin
                q.delete(); m_en = 0; m_lock = 0;
            end else begin
                if (stat_pop && q.size() > 0) void'(q.pop_back());
                if (pu) begin
                    if (q.size() < DEPTH) begin
                        q.push_back({1'b1, done_req_irq, done_jabber, done_underrun, done_max_coll, 3'b000});
                        m_evt = 1;
                    end else begin
                        q[q.size()-1] = q[q.size()-1] | 8'h04;
                    end
                end
                if (fat) begin
                    m_en = 0; m_lock = 1;
                end else if (cmd_valid && cmd_op == 5'd9 && !m_lock) begin
                    m_en = 1;
                end else if (cmd_valid && cmd_op == 5'd10) begin
                    m_en = 0;
                end
            end
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (model_on) begin
            chk(stat_byte == model_top(), "R1 R3 model stat_byte", stat_byte, model_top());
            chk(tx_enabled == m_en, "R7 R9 model tx_enabled", tx_enabled, m_en);
            chk(tx_done_evt == m_evt, "R6 model tx_done_evt", tx_done_evt, m_evt);
            chk(adapter_fail_evt == m_fail, "R8 model adapter_fail_evt", adapter_fail_evt, m_fail);
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic idle();
        done_valid = 0; done_req_irq = 0; done_jabber = 0; done_underrun = 0; done_max_coll = 0;
        data_overrun = 0; cmd_valid = 0; cmd_op = '0; stat_pop = 0;
    endtask

    // Hold the inputs set by the caller across one rising edge, then idle.
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic done(input bit rq, input bit jb, input bit un, input bit mc);
        done_valid = 1; done_req_irq = rq; done_jabber = jb; done_underrun = un; done_max_coll = mc;
    endtask

    task automatic cmd(input logic [4:0] op);
        cmd_valid = 1; cmd_op = op;
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11: state after reset
        chk(stat_byte == 8'h00, "R11 reset stat_byte", stat_byte, 8'h00);
        chk(tx_enabled == 0, "R11 reset tx_enabled", tx_enabled, 0);
        chk(tx_done_evt == 0 && adapter_fail_evt == 0, "R11 reset events", tx_done_evt, 0);
        model_on = 1;

        cmd(5'd9); step();
        chk(tx_enabled == 1, "R9 enable opcode", tx_enabled, 1);

        // R2: plain success without marker is not recorded
        done(0, 0, 0, 0); step();
        chk(stat_byte == 8'h00 && tx_done_evt == 0, "R2 skipped success", stat_byte, 8'h00);
        done(1, 0, 0, 0); step();
        chk(stat_byte == 8'hC0 && tx_done_evt == 1, "R2 requested success", stat_byte, 8'hC0);
        done(0, 0, 0, 1); step();
        chk(stat_byte == 8'h88, "R1 max collision record", stat_byte, 8'h88);
        // R3: pop reveals older record
        stat_pop = 1; step();
        chk(stat_byte == 8'hC0, "R3 pop exposes older", stat_byte, 8'hC0);
        stat_pop = 1; step();
        chk(stat_byte == 8'h00, "R4 empty after pops", stat_byte, 8'h00);
        stat_pop = 1; step();
        chk(stat_byte == 8'h00, "R4 pop on empty", stat_byte, 8'h00);

        // R5: overflow
        done(1, 0, 0, 0); step();
        done(1, 0, 0, 1); step();
        done(0, 0, 0, 1); step();
        done(1, 0, 0, 1); step();
        chk(stat_byte == 8'h8C, "R5 overflow marks top", stat_byte, 8'h8C);
        chk(tx_done_evt == 0, "R6 no event on dropped push", tx_done_evt, 0);
        stat_pop = 1; step();
        chk(stat_byte == 8'hC8, "R5 beneath has no overflow", stat_byte, 8'hC8);
        stat_pop = 1; step();
        stat_pop = 1; step();
        chk(stat_byte == 8'h00, "R5 drained", stat_byte, 8'h00);

        // R10: pop and push in one cycle
        done(1, 0, 0, 0); step();
        done(0, 0, 0, 1); stat_pop = 1; step();
        chk(stat_byte == 8'h88, "R10 pop before push", stat_byte, 8'h88);
        stat_pop = 1; step();
        chk(stat_byte == 8'h00, "R10 single record held", stat_byte, 8'h00);

        // R7: jabber locks the transmitter
        done(0, 1, 0, 0); step();
        chk(stat_byte == 8'hA0 && tx_enabled == 0, "R7 jabber disables", stat_byte, 8'hA0);
        cmd(5'd9); step();
        chk(tx_enabled == 0, "R7 enable ignored while locked", tx_enabled, 0);
        cmd(5'd11); step();
        chk(stat_byte == 8'h00 && tx_enabled == 0, "R9 tx reset clears", stat_byte, 8'h00);
        cmd(5'd9); step();
        chk(tx_enabled == 1, "R9 enable after reset", tx_enabled, 1);

        // R8: data overrun
        data_overrun = 1; step();
        chk(adapter_fail_evt == 1 && tx_enabled == 0, "R8 overrun fail event", adapter_fail_evt, 1);
        cmd(5'd9); step();
        chk(adapter_fail_evt == 0 && tx_enabled == 0, "R8 pulse ends and lock holds", tx_enabled, 0);
        cmd(5'd0); step();
        cmd(5'd9); step();
        chk(tx_enabled == 1, "R9 global reset unlocks", tx_enabled, 1);

        // R10: reset opcode beats a jabber outcome
        done(1, 1, 0, 0); cmd(5'd11); step();
        chk(stat_byte == 8'h00 && tx_done_evt == 0, "R10 reset beats push", stat_byte, 8'h00);
        cmd(5'd9); step();
        chk(tx_enabled == 1, "R10 reset beats lock", tx_enabled, 1);

        // R9: unused opcode ignored, then disable
        cmd(5'd3); step();
        chk(tx_enabled == 1, "R9 unused opcode", tx_enabled, 1);
        cmd(5'd10); step();
        chk(tx_enabled == 0, "R9 disable opcode", tx_enabled, 0);

        // Random phase, checked by the model every cycle.
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 45) done($urandom_range(0, 1), ($urandom_range(0, 15) == 0),
                             ($urandom_range(0, 15) == 0), $urandom_range(0, 1));
            stat_pop = ($urandom_range(0, 2) == 0);
            data_overrun = ($urandom_range(0, 60) == 0);
            if ($urandom_range(0, 9) == 0) begin
                case ($urandom_range(0, 5))
                    0: cmd(5'd0);
                    1: cmd(5'd11);
                    2: cmd(5'd10);
                    3: cmd(5'd7);
                    default: cmd(5'd9);
                endcase
            end
            step();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule